// File: doc/BRIEF.md
# Dual-Tone Alert Guard-Time Qualifier

This block turns the raw "both tones present" flag of a dual-tone alert detector into a qualified steering output. It replaces the usual capacitor-and-comparator guard-time network with a tick-driven counter. A burst of tone counts as valid only once the raw flag has been high for a programmable tone-present guard time. Once the output is high, it stays high through dropouts of the raw flag that are shorter than a separate, programmable tone-absent guard time.

Both guard times are counted in ticks of a 1 ms strobe. The defaults are 22 ticks for the present time and 16 ticks for the absent time. With these values, tone must be seen together for at least 20 ms before it is accepted. After the tone ends, and once an upstream dropout-detect delay of up to 8 ms is added, the output falls within 15 to 25 ms. A detection-disable input keeps the qualified output low while the guard logic goes on tracking the raw flag. A power-down input returns the whole guard state to idle. A status output shows the internal guard state, for debug and for an interrupt combiner.

Top module: `guard_qual`

## Requirements
- R1: After reset, `steerQual` and `guardState` are both 0.
- R2: With `guardState` low, `guardState` and `steerQual` rise on the clock edge that samples the PRESENT_TICKS-th `msTick` seen while `earlySteer` has stayed continuously high.
- R3: If `earlySteer` falls before PRESENT_TICKS ticks have been counted, the output stays low and the count restarts from zero at the next rise of `earlySteer`.
- R4: With `guardState` high, a low period of `earlySteer` that spans fewer than ABSENT_TICKS ticks leaves `steerQual` high.
- R5: With `guardState` high, `guardState` and `steerQual` fall on the edge that samples the ABSENT_TICKS-th tick seen while `earlySteer` has stayed continuously low.
- R6: While `detectDisable` is 1, `steerQual` is 0, and `guardState` still qualifies and releases exactly as in R2 and R5.
- R7: While `powerDown` is 1, both outputs are 0 from the next edge on. After release, a full PRESENT_TICKS period is needed again.
- R8: `steerQual` follows `detectDisable` in the same cycle when `guardState` is high: it is high exactly when `guardState` is 1 and `detectDisable` is 0.
- R9: While `earlySteer` equals `guardState`, ticks have no effect and the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle 1 ms timebase strobe |
| earlySteer | input | 1 | Raw both-tones-present flag |
| detectDisable | input | 1 | Hold the qualified output low |
| powerDown | input | 1 | Force the guard state to idle |
| steerQual | output | 1 | Guard-time qualified steering output |
| guardState | output | 1 | Internal guard state, for status |

## Verification
The bench builds the block with PRESENT_TICKS=5 and ABSENT_TICKS=3, and it issues a tick every fourth clock. With these values, every guard window ends within a few dozen cycles, so each boundary can be hit exactly. The bench checks one tick short of qualification, the qualifying tick itself, and a dropout one tick short of release. Because the present time is longer than the absent time, as in the default configuration, the bench can also check asymmetric behaviour: a short burst is rejected while a dropout of the same kind of length is bridged.

// File: rtl/guard_pkg.sv
package guard_pkg;
  // Strobes from control to the guard counter datapath.
  typedef struct packed {
    logic clear;    // return the counter to zero
    logic advance;  // count one more qualifying tick
    logic flip;     // guard window complete; state toggles
  } guardStrobes_t;
endpackage

// File: rtl/guard_count_dp.sv
module guard_count_dp
  import guard_pkg::*;
#(
  parameter int PRESENT_TICKS = 22,
  parameter int ABSENT_TICKS  = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobes_t strobes,
  input  logic          limitSel,   // 0: present window, 1: absent window
  output logic          lastTick    // next qualifying tick completes the window
);
  localparam int MAX_TICKS = (PRESENT_TICKS > ABSENT_TICKS) ? PRESENT_TICKS : ABSENT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] PRES_LAST = CNT_W'(PRESENT_TICKS - 1);
  localparam logic [CNT_W-1:0] ABS_LAST  = CNT_W'(ABSENT_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_TOP   = {CNT_W{1'b1}};

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastValue;

  always_comb begin
    lastValue = limitSel ? ABS_LAST : PRES_LAST;
    lastTick  = (tickCnt >= lastValue);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobes.clear) begin
      tickCnt <= '0;
    end else if (strobes.advance && (tickCnt != CNT_TOP)) begin
      tickCnt <= tickCnt + 1'b1;  // saturating, never wraps
    end
  end
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          msTick,
  input  logic          earlySteer,
  input  logic          powerDown,
  input  logic          lastTick,
  output guardStrobes_t strobes,
  output logic          stateQ
);
  logic mismatch;

  always_comb begin
    mismatch        = (earlySteer != stateQ);
    strobes.flip    = !powerDown && mismatch && msTick && lastTick;
    strobes.advance = !powerDown && mismatch && msTick && !lastTick;
    strobes.clear   = powerDown || !mismatch || strobes.flip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= 1'b0;
    end else if (powerDown) begin
      stateQ <= 1'b0;
    end else if (strobes.flip) begin
      stateQ <= ~stateQ;
    end
  end
endmodule

// File: rtl/guard_qual.sv
module guard_qual
  import guard_pkg::*;
#(
  parameter int PRESENT_TICKS = 22,
  parameter int ABSENT_TICKS  = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic earlySteer,
  input  logic detectDisable,
  input  logic powerDown,
  output logic steerQual,
  output logic guardState
);
  guardStrobes_t strobes;
  logic          lastTick;
  logic          stateQ;

  guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .earlySteer (earlySteer),
    .powerDown  (powerDown),
    .lastTick   (lastTick),
    .strobes    (strobes),
    .stateQ     (stateQ)
  );

  guard_count_dp #(
    .PRESENT_TICKS (PRESENT_TICKS),
    .ABSENT_TICKS  (ABSENT_TICKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .limitSel (stateQ),
    .lastTick (lastTick)
  );

  assign guardState = stateQ;
  assign steerQual  = stateQ & ~detectDisable;
endmodule

// File: rtl/guard_qual_checker.sv
module guard_qual_checker #(
  parameter int PRESENT_TICKS = 22,
  parameter int ABSENT_TICKS  = 16
) (
  input logic clk,
  input logic rstN,
  input logic msTick,
  input logic earlySteer,
  input logic detectDisable,
  input logic powerDown,
  input logic steerQual,
  input logic guardState
);
  // Independent count of ticks seen while the raw flag is high and state low.
  logic [15:0] presCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presCnt <= '0;
    else if (powerDown || !earlySteer || guardState) presCnt <= '0;
    else if (msTick && presCnt != 16'hFFFF) presCnt <= presCnt + 1'b1;
  end

  assert_present_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardState) |-> ($past(presCnt) == 16'(PRESENT_TICKS - 1)));

  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardState) |-> $past(msTick && earlySteer && !powerDown));

  assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(guardState) |-> $past(powerDown || (msTick && !earlySteer)));

  assert_pd_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !guardState);

  assert_disable_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    detectDisable |-> !steerQual);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (earlySteer == guardState && !powerDown) |=> $stable(guardState));
endmodule

bind guard_qual guard_qual_checker #(
  .PRESENT_TICKS (PRESENT_TICKS),
  .ABSENT_TICKS  (ABSENT_TICKS)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .msTick        (msTick),
  .earlySteer    (earlySteer),
  .detectDisable (detectDisable),
  .powerDown     (powerDown),
  .steerQual     (steerQual),
  .guardState    (guardState)
);

// File: tb/guard_qual_bench.sv
module guard_qual_bench;
  localparam int P = 5;
  localparam int A = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic earlySteer = 1'b0;
  logic detectDisable = 1'b0;
  logic powerDown = 1'b0;
  logic steerQual;
  logic guardState;

  int checks = 0;
  int fails = 0;
  int divCnt = 0;

  always #4 clk = ~clk;

  // one-cycle tick every fourth clock, driven away from the active edge
  always @(negedge clk) begin
    divCnt = (divCnt == 3) ? 0 : divCnt + 1;
    msTick = (divCnt == 3);
  end

  guard_qual #(.PRESENT_TICKS(P), .ABSENT_TICKS(A)) u_guard_qual (
    .clk(clk), .rstN(rstN), .msTick(msTick), .earlySteer(earlySteer),
    .detectDisable(detectDisable), .powerDown(powerDown),
    .steerQual(steerQual), .guardState(guardState)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // returns just after the edge that samples the n-th tick
  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!msTick) @(posedge clk);
    end
  endtask

  task automatic goIdle();
    @(negedge clk);
    earlySteer = 1'b0;
    waitTicks(A + 1);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 steer", steerQual, 1'b0);
    check("R1 state", guardState, 1'b0);
  endtask

  task automatic testQualify();
    @(negedge clk); earlySteer = 1'b1;
    waitTicks(P - 1); @(negedge clk);
    check("R2 one tick short", steerQual, 1'b0);
    waitTicks(1); @(negedge clk);
    check("R2 qualified", steerQual, 1'b1);
    check("R2 state", guardState, 1'b1);
    goIdle();
  endtask

  task automatic testShortBurst();
    @(negedge clk); earlySteer = 1'b1;
    waitTicks(P - 1); @(negedge clk);
    earlySteer = 1'b0;
    waitTicks(2); @(negedge clk);
    check("R3 burst rejected", steerQual, 1'b0);
    earlySteer = 1'b1;
    waitTicks(P - 1); @(negedge clk);
    check("R3 count restarted", steerQual, 1'b0);
    waitTicks(1); @(negedge clk);
    check("R3 full window", steerQual, 1'b1);
    goIdle();
  endtask

  task automatic testDropout();
    @(negedge clk); earlySteer = 1'b1;
    waitTicks(P); @(negedge clk);
    earlySteer = 1'b0;
    waitTicks(A - 1); @(negedge clk);
    check("R4 dropout bridged", steerQual, 1'b1);
    earlySteer = 1'b1;
    waitTicks(A + 4); @(negedge clk);
    check("R9 held while agreeing", steerQual, 1'b1);
    earlySteer = 1'b0;
    waitTicks(A - 1); @(negedge clk);
    check("R5 one tick short", steerQual, 1'b1);
    waitTicks(1); @(negedge clk);
    check("R5 released", steerQual, 1'b0);
    check("R5 state", guardState, 1'b0);
    waitTicks(P + 2); @(negedge clk);
    check("R9 idle held", guardState, 1'b0);
  endtask

  task automatic testDisable();
    @(negedge clk); detectDisable = 1'b1; earlySteer = 1'b1;
    waitTicks(P); @(negedge clk);
    check("R6 output held low", steerQual, 1'b0);
    check("R6 state qualified", guardState, 1'b1);
    detectDisable = 1'b0; #1;
    check("R8 same-cycle release", steerQual, 1'b1);
    @(negedge clk); detectDisable = 1'b1; #1;
    check("R8 same-cycle hold", steerQual, 1'b0);
    @(negedge clk); earlySteer = 1'b0;
    waitTicks(A); @(negedge clk);
    check("R6 state released", guardState, 1'b0);
    detectDisable = 1'b0;
  endtask

  task automatic testPowerDown();
    @(negedge clk); earlySteer = 1'b1;
    waitTicks(P); @(negedge clk);
    check("R7 pre", steerQual, 1'b1);
    powerDown = 1'b1;
    @(negedge clk);
    check("R7 steer forced", steerQual, 1'b0);
    check("R7 state idle", guardState, 1'b0);
    waitTicks(P + 1); @(negedge clk);
    check("R7 held in power-down", guardState, 1'b0);
    powerDown = 1'b0;
    waitTicks(P - 1); @(negedge clk);
    check("R7 full window needed", steerQual, 1'b0);
    waitTicks(1); @(negedge clk);
    check("R7 requalified", steerQual, 1'b1);
    goIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testQualify();
    testShortBurst();
    testDropout();
    testDisable();
    testPowerDown();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule